// File: doc/BRIEF.md
# AUX Request/Reply Transaction Framer

This block runs a single request/reply exchange on a DisplayPort-style auxiliary channel at the byte level. The host sets a 4-bit request code, a 20-bit target address, a transfer length of 0 to 16 bytes and, for writes, a payload, and then pulses `go`. The block checks the request. It streams a compact header and any payload to a byte transmitter over a valid/ready handshake, then waits for the reply bytes from a byte receiver.

The header is built from nibble-split fields. The request code shares its first byte with the top four address bits. The next two bytes carry the rest of the address. A fourth byte holds the length minus one, and this byte is left out for a zero-length request. The first reply byte carries the reply code in its upper nibble, and any bytes after it are read data. At the end the block raises a sticky done flag and presents a status word: the received byte count, a timeout flag, a receive-error flag and a reject flag. The host must clear done before it can start the next transaction.

Top module: `aux_txn_framer`

## Requirements
- R1: The first transmitted byte is {request code, address[19:16]}. The second is address[15:8] and the third is address[7:0].
- R2: When the length is nonzero, a fourth header byte equal to length minus one follows. When the length is zero, only the three address bytes are sent.
- R3: The number of bytes sent is 3, plus 1 if the length is nonzero, plus the length for a write. Payload byte k is `wr_data[8k+7:8k]` and is sent in increasing k. `tx_valid` stays high from the first byte to the last.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R5: The request code is classified with bit 2 (the middle-of-transaction flag) ignored. 0x8 is a native write, 0x9 a native read, 0x0 an I2C write and 0x1 an I2C read. Any other code is rejected: no byte is sent, done rises on the next clock, and status reads 0x0000_0004 (bit 2 = reject).
- R6: A length above 16 is rejected in the same way as R5.
- R7: When the reply succeeds, `reply_code` is bits 7:4 of the first reply byte, and reply byte j (j ≥ 1) appears in `rd_data` byte j-1. For a read, `xfer_count` is the received byte count minus one. Unfilled data bytes read as zero.
- R8: The status word holds the received byte count in bits 28:24, the reject flag in bit 2, the timeout flag in bit 1 and the receive-error flag in bit 0. All other bits are zero.
- R9: For a successful write, `xfer_count` equals the requested length, whatever number of reply bytes arrived.
- R10: After the last transmitted byte, and after each reply byte, a counter runs. A reply byte that arrives after TIMEOUT_CYCLES-1 idle cycles is accepted. TIMEOUT_CYCLES idle cycles set the timeout flag and end the transaction.
- R11: Any `rx_err_flags` bit on a reply byte, or more than 17 reply bytes, sets the error flag. On error or timeout, `reply_code`, `xfer_count` and `rd_data` all read zero.
- R12: `done` rises on the second clock edge after the last reply byte is accepted (rx_last). It holds until `done_ack` and then clears on the next edge. A `go` that arrives while `done` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse for a transaction |
| req_code | input | 4 | Request code |
| req_addr | input | 20 | Target address |
| req_len | input | LW (5) | Transfer length in bytes |
| wr_data | input | MAX_LEN*8 | Write payload, byte 0 in the low bits |
| tx_data | output | 8 | Byte to transmitter |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmitter accepts byte |
| rx_data | input | 8 | Byte from receiver |
| rx_valid | input | 1 | Receive byte valid |
| rx_last | input | 1 | Marks the final reply byte |
| rx_err_flags | input | 6 | Receive fault flags for the current byte: overflow, partial byte, disconnect, bad sync, bad start, bad symbol |
| done | output | 1 | Sticky completion flag |
| done_ack | input | 1 | Clears done |
| status | output | 32 | Completion status word |
| reply_code | output | 4 | Reply code from first reply byte |
| rd_data | output | MAX_LEN*8 | Read data, byte 0 in the low bits |
| xfer_count | output | LW (5) | Transferred data byte count |

## Verification
A wrong byte index or a wrong length decode shows up on `tx_data` at the handshake of the first byte it affects, so the check against the expected header and payload catches it within the request. A wrong receive count or wrong slot selection shows in the status count field and in `rd_data` as soon as done rises. An off-by-one in the idle counter moves the timeout boundary and is exposed by the TIMEOUT_CYCLES-1 and TIMEOUT_CYCLES delay cases. A bad done path shows as a wrong completion latency, or as a new request that starts while done is still high.

// File: rtl/aux_txn_pkg.sv
package aux_txn_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_FIN
  } aux_state_e;

  localparam logic [3:0] CODE_NAT_WR  = 4'h8;
  localparam logic [3:0] CODE_NAT_RD  = 4'h9;
  localparam logic [3:0] CODE_I2C_WR  = 4'h0;
  localparam logic [3:0] CODE_I2C_RD  = 4'h1;
  localparam logic [3:0] MOT_MASK     = 4'h4;

  function automatic logic code_is_write(input logic [3:0] code);
    logic [3:0] base;
    base = code & ~MOT_MASK;
    return (base == CODE_NAT_WR) || (base == CODE_I2C_WR);
  endfunction

  function automatic logic code_is_known(input logic [3:0] code);
    logic [3:0] base;
    base = code & ~MOT_MASK;
    return (base == CODE_NAT_WR) || (base == CODE_I2C_WR) ||
           (base == CODE_NAT_RD) || (base == CODE_I2C_RD);
  endfunction

endpackage

// File: rtl/aux_req_builder.sv
module aux_req_builder #(
  parameter  int MAX_LEN = 16,
  localparam int LW      = $clog2(MAX_LEN + 2),
  localparam int IW      = $clog2(MAX_LEN + 5)
) (
  input  logic [3:0]           code_i,
  input  logic [19:0]          addr_i,
  input  logic [LW-1:0]        len_i,
  input  logic                 wr_i,
  input  logic [MAX_LEN*8-1:0] payload_i,
  input  logic [IW-1:0]        idx_i,
  output logic [7:0]           byte_o,
  output logic [IW-1:0]        total_o
);

  logic has_len;

  always_comb begin
    has_len = (len_i != '0);
    total_o = IW'(3) + IW'(has_len) + (wr_i ? IW'(len_i) : IW'(0));
  end

  // Byte select: three address bytes, optional length byte, then payload
  always_comb begin
    byte_o = 8'h00;
    if (idx_i == IW'(0)) begin
      byte_o = {code_i, addr_i[19:16]};
    end else if (idx_i == IW'(1)) begin
      byte_o = addr_i[15:8];
    end else if (idx_i == IW'(2)) begin
      byte_o = addr_i[7:0];
    end else if (idx_i == IW'(3)) begin
      byte_o = 8'(len_i - LW'(1));
    end else begin
      for (int k = 0; k < MAX_LEN; k++) begin
        if (idx_i == IW'(k + 4)) byte_o = payload_i[k*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/aux_reply_collector.sv
module aux_reply_collector #(
  parameter  int MAX_LEN = 16,
  localparam int CW      = $clog2(MAX_LEN + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 cap_i,
  input  logic [7:0]           byte_i,
  input  logic                 flag_i,
  output logic [CW-1:0]        cnt_o,
  output logic [3:0]           code_o,
  output logic [MAX_LEN*8-1:0] data_o,
  output logic                 err_o
);

  localparam logic [CW-1:0] FULL = CW'(MAX_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    code_q, code_d;
  logic          err_q, err_d;

  always_comb begin
    cnt_d  = cnt_q;
    code_d = code_q;
    err_d  = err_q;
    if (clr_i) begin
      cnt_d  = '0;
      code_d = '0;
      err_d  = 1'b0;
    end else if (cap_i) begin
      if (cnt_q == '0) code_d = byte_i[7:4];
      if (cnt_q != FULL) cnt_d = cnt_q + CW'(1);
      if (flag_i || (cnt_q == FULL)) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      code_q <= code_d;
      err_q  <= err_d;
    end
  end

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (clr_i) begin
        slot_q <= '0;
      end else if (cap_i && (cnt_q == CW'(g + 1))) begin
        slot_q <= byte_i;
      end
    end
    assign data_o[g*8 +: 8] = slot_q;
  end

  assign cnt_o  = cnt_q;
  assign code_o = code_q;
  assign err_o  = err_q;

  // R8: count saturates at one reply code byte plus MAX_LEN data bytes
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  // R7: reply code comes from the first byte only
  p_code_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && !clr_i && (cnt_q != '0)) |=> $stable(code_o));

endmodule

// File: rtl/aux_reply_timer.sv
module aux_reply_timer #(
  parameter  int LIMIT = 400,
  localparam int TW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o,
  output logic flag_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;

  always_comb begin
    expire_o = run_i && !kick_i && (cnt_q == TW'(LIMIT - 1));
    cnt_d    = (!run_i || kick_i) ? '0 : cnt_q + TW'(1);
    flag_d   = flag_q;
    if (clr_i)         flag_d = 1'b0;
    else if (expire_o) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R10: timeout only rises after a waiting cycle without a reply byte
  p_timeout_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> ($past(run_i) && !$past(kick_i)));

endmodule

// File: rtl/aux_txn_framer.sv
module aux_txn_framer
  import aux_txn_pkg::*;
#(
  parameter  int MAX_LEN        = 16,
  parameter  int TIMEOUT_CYCLES = 400,
  localparam int LW             = $clog2(MAX_LEN + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [3:0]           req_code,
  input  logic [19:0]          req_addr,
  input  logic [LW-1:0]        req_len,
  input  logic [MAX_LEN*8-1:0] wr_data,
  output logic [7:0]           tx_data,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  input  logic [7:0]           rx_data,
  input  logic                 rx_valid,
  input  logic                 rx_last,
  input  logic [5:0]           rx_err_flags,
  output logic                 done,
  input  logic                 done_ack,
  output logic [31:0]          status,
  output logic [3:0]           reply_code,
  output logic [MAX_LEN*8-1:0] rd_data,
  output logic [LW-1:0]        xfer_count
);

  localparam int IW = $clog2(MAX_LEN + 5);

  aux_state_e           st_q, st_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic [3:0]           code_q;
  logic [19:0]          addr_q;
  logic [LW-1:0]        len_q;
  logic [MAX_LEN*8-1:0] pay_q;
  logic                 wr_q;
  logic                 done_q, done_d;
  logic                 rej_q, rej_d;
  logic                 go_take, req_bad, load;

  logic [7:0]           bld_byte;
  logic [IW-1:0]        bld_total;
  logic [LW-1:0]        col_cnt;
  logic [3:0]           col_code;
  logic [MAX_LEN*8-1:0] col_data;
  logic                 col_err;
  logic                 tmr_expire, tmr_flag;
  logic                 deliver;

  // Next-state logic
  always_comb begin
    go_take = (st_q == ST_IDLE) && go && !done_q;
    req_bad = !code_is_known(req_code) || (req_len > LW'(MAX_LEN));
    load    = go_take && !req_bad;
    st_d    = st_q;
    idx_d   = idx_q;
    rej_d   = rej_q;
    done_d  = done_q && !done_ack;
    case (st_q)
      ST_IDLE: begin
        if (go_take) begin
          rej_d = req_bad;
          idx_d = '0;
          if (req_bad) done_d = 1'b1;
          else         st_d   = ST_SEND;
        end
      end
      ST_SEND: begin
        if (tx_ready) begin
          idx_d = idx_q + IW'(1);
          if (idx_q == bld_total - IW'(1)) st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if ((rx_valid && rx_last) || tmr_expire) st_d = ST_FIN;
      end
      ST_FIN: begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      code_q <= '0;
      addr_q <= '0;
      len_q  <= '0;
      pay_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      rej_q  <= rej_d;
      if (load) begin
        code_q <= req_code;
        addr_q <= req_addr;
        len_q  <= req_len;
        pay_q  <= wr_data;
        wr_q   <= code_is_write(req_code);
      end
    end
  end

  aux_req_builder #(.MAX_LEN(MAX_LEN)) i_builder (
    .code_i    (code_q),
    .addr_i    (addr_q),
    .len_i     (len_q),
    .wr_i      (wr_q),
    .payload_i (pay_q),
    .idx_i     (idx_q),
    .byte_o    (bld_byte),
    .total_o   (bld_total)
  );

  aux_reply_collector #(.MAX_LEN(MAX_LEN)) i_collector (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (go_take),
    .cap_i  ((st_q == ST_WAIT) && rx_valid),
    .byte_i (rx_data),
    .flag_i (|rx_err_flags),
    .cnt_o  (col_cnt),
    .code_o (col_code),
    .data_o (col_data),
    .err_o  (col_err)
  );

  aux_reply_timer #(.LIMIT(TIMEOUT_CYCLES)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (go_take),
    .run_i    (st_q == ST_WAIT),
    .kick_i   (rx_valid),
    .expire_o (tmr_expire),
    .flag_o   (tmr_flag)
  );

  // Outputs
  always_comb begin
    tx_valid = (st_q == ST_SEND);
    tx_data  = bld_byte;
    done     = done_q;
    deliver  = (st_q == ST_IDLE) && !tmr_flag && !col_err && !rej_q;
    status   = '0;
    status[24 +: LW] = col_cnt;
    status[2:0]      = {rej_q, tmr_flag, col_err};
    reply_code = deliver ? col_code : 4'h0;
    rd_data    = deliver ? col_data : '0;
    if (!deliver)           xfer_count = '0;
    else if (wr_q)          xfer_count = len_q;
    else if (col_cnt != '0) xfer_count = col_cnt - LW'(1);
    else                    xfer_count = '0;
  end

  // R4: byte held under backpressure
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R12: done sticky until acknowledged
  p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ack) |=> done);

  // R11: no data count alongside a failure flag
  p_no_delivery_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_count != '0) |-> (status[2:0] == 3'b000));

  // R5: a rejected request sends nothing
  p_reject_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> !tx_valid);

endmodule

// File: tb/test_aux_txn_framer.sv
module test_aux_txn_framer;

  localparam int ML = 16;
  localparam int TO = 6;

  logic          clk, rst_n, go, tx_ready, rx_valid, rx_last, done_ack;
  logic [3:0]    req_code;
  logic [19:0]   req_addr;
  logic [4:0]    req_len;
  logic [ML*8-1:0] wr_data;
  logic [7:0]    tx_data, rx_data;
  logic          tx_valid, done;
  logic [5:0]    rx_err_flags;
  logic [31:0]   status;
  logic [3:0]    reply_code;
  logic [ML*8-1:0] rd_data;
  logic [4:0]    xfer_count;

  int n_chk = 0;
  int n_bad = 0;

  aux_txn_framer #(.MAX_LEN(ML), .TIMEOUT_CYCLES(TO)) i_aux_txn_framer (
    .clk(clk), .rst_n(rst_n), .go(go), .req_code(req_code), .req_addr(req_addr),
    .req_len(req_len), .wr_data(wr_data), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .rx_err_flags(rx_err_flags), .done(done), .done_ack(done_ack), .status(status),
    .reply_code(reply_code), .rd_data(rd_data), .xfer_count(xfer_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int k, input int len, input logic [19:0] a);
    return 8'(int'(a[7:0]) ^ (k * 17 + len * 5 + 3));
  endfunction

  function automatic logic [7:0] rxb(input int j, input int len, input logic [19:0] a);
    if (j == 0) return {4'(int'(a[3:0]) + len), 4'hA};
    return 8'(int'(a[7:0]) + j * 29 + len * 3);
  endfunction

  function automatic logic [7:0] exp_tx(input int i, input logic [3:0] c,
                                        input logic [19:0] a, input int len);
    if (i == 0) return {c, a[19:16]};
    if (i == 1) return a[15:8];
    if (i == 2) return a[7:0];
    if (i == 3) return 8'(len - 1);
    return pay(i - 4, len, a);
  endfunction

  task automatic do_txn(input logic [3:0] c, input logic [19:0] a, input int len,
                        input int delay, input int nrx, input logic [5:0] eflag,
                        input int eidx, input bit stall, input bit no_reply,
                        input bit skip_ack);
    logic [3:0] base;
    bit wr, valid, e_to, e_err, e_ok;
    int total, ntx, cyc, hdr_bad, pay_bad, gap, lat, e_cnt;
    logic [ML*8-1:0] e_rd;
    logic [31:0] e_st;
    base  = c & 4'hB;
    wr    = (base == 4'h8) || (base == 4'h0);
    valid = ((base == 4'h8) || (base == 4'h9) || (base == 4'h0) || (base == 4'h1));
    @(negedge clk);
    req_code = c; req_addr = a; req_len = 5'(len);
    for (int k = 0; k < ML; k++) wr_data[k*8 +: 8] = pay(k, len, a);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    if (!valid || len > ML) begin
      if (!valid) chk("R5 reject code", {done, tx_valid, status, xfer_count},
                      {1'b1, 1'b0, 32'h4, 5'd0});
      else        chk("R6 reject length", {done, tx_valid, status, xfer_count},
                      {1'b1, 1'b0, 32'h4, 5'd0});
    end else begin
      total = 3 + ((len != 0) ? 1 : 0) + (wr ? len : 0);
      ntx = 0; cyc = 0; hdr_bad = 0; pay_bad = 0; gap = 0;
      while (ntx < total && cyc < 400) begin
        tx_ready = stall ? ((cyc % 3) != 2) : 1'b1;
        if (!tx_valid) gap++;
        else if (tx_ready) begin
          if (tx_data !== exp_tx(ntx, c, a, len)) begin
            if (ntx < 4) hdr_bad++; else pay_bad++;
          end
          ntx++;
        end
        @(negedge clk);
        cyc++;
      end
      tx_ready = 1'b0;
      if (tx_valid) gap++;
      chk("R1 R2 header bytes", 160'(hdr_bad), 160'd0);
      chk("R3 count and payload", {32'(ntx), 32'(pay_bad), 32'(gap)},
          {32'(total), 32'd0, 32'd0});
      repeat (delay) @(negedge clk);
      if (!no_reply) begin
        for (int j = 0; j < nrx; j++) begin
          rx_valid = 1'b1; rx_data = rxb(j, len, a); rx_last = (j == nrx - 1);
          rx_err_flags = (j == eidx) ? eflag : 6'd0;
          @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0; rx_err_flags = 6'd0;
      end
      lat = 0;
      while (!done && lat < 100) begin @(negedge clk); lat++; end
      e_to  = no_reply || (delay >= TO);
      e_err = !e_to && ((eflag != 0) || (nrx > ML + 1));
      e_ok  = !e_to && !e_err;
      e_cnt = e_to ? 0 : ((nrx > ML + 1) ? ML + 1 : nrx);
      if (no_reply) chk("R10 timeout latency", 160'(lat), 160'(TO + 1));
      else if (!e_to) chk("R12 done latency", 160'(lat), 160'd1);
      e_st = {3'b0, 5'(e_cnt), 21'b0, 1'b0, e_to, e_err};
      if (e_to) chk("R10 timeout status", status, e_st);
      else if (e_err) chk("R11 error status", status, e_st);
      else chk("R8 status word", status, e_st);
      e_rd = '0;
      if (e_ok) for (int j = 1; j < nrx && j <= ML; j++) e_rd[(j-1)*8 +: 8] = rxb(j, len, a);
      if (e_ok) chk("R7 reply code and data", {reply_code, rd_data},
                    {rxb(0, len, a) >> 4, e_rd});
      else chk("R11 no delivery", {reply_code, rd_data, xfer_count}, '0);
      if (e_ok && wr) chk("R9 write count", 160'(xfer_count), 160'(len));
      else if (e_ok) chk("R7 read count", 160'(xfer_count), 160'(nrx - 1));
    end
    if (!skip_ack) begin
      @(negedge clk); done_ack = 1'b1;
      @(negedge clk); done_ack = 1'b0;
      chk("R12 ack clears done", 160'(done), 160'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    int gaps;
    rst_n = 1'b0; go = 1'b0; tx_ready = 1'b0; rx_valid = 1'b0; rx_last = 1'b0;
    done_ack = 1'b0; req_code = '0; req_addr = '0; req_len = '0; wr_data = '0;
    rx_data = '0; rx_err_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset state", {done, tx_valid, status, xfer_count, reply_code},
        {1'b0, 1'b0, 32'h0, 5'd0, 4'd0});

    // Sweep all codes across lengths including the reject boundary
    for (int c = 0; c < 16; c++) begin
      for (int li = 0; li < 6; li++) begin
        int ln, lens[6];
        bit rd;
        lens = '{0, 1, 2, 5, 16, 17};
        ln = lens[li];
        rd = ((c & 4'hB) == 9) || ((c & 4'hB) == 1);
        do_txn(4'(c), 20'h5A3C1 ^ 20'(c * 4099 + ln), ln, c % 3,
               rd ? ln + 1 : 1, 6'd0, 0, 1'b0, 1'b0, 1'b0);
      end
    end
    // Full length sweep on native write and native read
    for (int ln = 0; ln <= 17; ln++) begin
      do_txn(4'h8, 20'hC0DE0 + 20'(ln), ln, 1, 1, 6'd0, 0, 1'b0, 1'b0, 1'b0);
      do_txn(4'h9, 20'h31F07 + 20'(ln), ln, 2, ln + 1, 6'd0, 0, 1'b0, 1'b0, 1'b0);
    end
    // R4 backpressure on write with middle-of-transaction bit
    do_txn(4'hC, 20'hABCDE, 9, 0, 1, 6'd0, 0, 1'b1, 1'b0, 1'b0);
    do_txn(4'hD, 20'h01234, 7, 0, 8, 6'd0, 0, 1'b1, 1'b0, 1'b0);
    // R10 timeout boundary
    do_txn(4'h9, 20'h44444, 3, TO - 1, 4, 6'd0, 0, 1'b0, 1'b0, 1'b0);
    do_txn(4'h9, 20'h55555, 3, TO, 4, 6'd0, 0, 1'b0, 1'b0, 1'b0);
    do_txn(4'h1, 20'h66666, 2, 0, 0, 6'd0, 0, 1'b0, 1'b1, 1'b0);
    // R11 each receive fault flag, and overflow
    for (int b = 0; b < 6; b++)
      do_txn(4'h9, 20'h70000 + 20'(b), 4, 0, 5, 6'(1 << b), b % 3, 1'b0, 1'b0, 1'b0);
    do_txn(4'h9, 20'h7ABCD, 16, 0, 18, 6'd0, 0, 1'b0, 1'b0, 1'b0);
    // R9 write with extra reply bytes
    do_txn(4'h0, 20'h12345, 5, 1, 3, 6'd0, 0, 1'b0, 1'b0, 1'b0);
    // R12 go ignored while done is still set
    do_txn(4'h9, 20'h2468A, 4, 0, 5, 6'd0, 0, 1'b0, 1'b0, 1'b1);
    held = status;
    @(negedge clk);
    req_code = 4'h8; req_len = 5'd3; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    gaps = 0;
    for (int i = 0; i < 4; i++) begin
      if (tx_valid) gaps++;
      @(negedge clk);
    end
    chk("R12 go ignored while done", {32'(gaps), done, status}, {32'd0, 1'b1, held});
    done_ack = 1'b1;
    @(negedge clk);
    done_ack = 1'b0;
    chk("R12 ack after ignored go", 160'(done), 160'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule